// File: doc/BRIEF.md
# Packet Convolutional Encoder with Selectable Trellis Termination

This block turns whole packets of data bits into rate-1/2 coded symbol pairs with a constraint-length-7 code. Bits arrive one per accepted handshake on a valid/ready write port and collect in a local buffer. When the packet's final bit is accepted, the block picks a termination scheme from `cfg_mode` and then streams the coded pairs out on a valid/ready port. The final pair of each packet is flagged.

Four schemes are offered. Plain truncation clears the encoder and stops after the data. Zero-tail clears the encoder and appends six zero inputs, so the coder ends in state zero. The two tail-biting schemes fill the six-stage delay line from buffered packet bits before any symbol leaves, and emit nothing while they do. In the first scheme the fill uses the packet's closing six bits. In the second it uses the opening six bits, which are then encoded again at the end. Either way the coder ends in the state it started from, and no extra symbols are sent.

A debug flag reports, after each packet, whether the final register state equals the state encoding began from. A one-cycle error pulse rejects tail-biting packets too short to fill the delay line.

Top module: `conv_pkt_encoder`

## Requirements
- R1: While reset is held and after it is released, `out_valid`, `err_short` and `state_match` are 0 and `in_ready` is 1.
- R2: Each symbol is formed from a 7-bit window w, where w[6] is the current encoder input, w[5] is the previous input and w[0] is the input six steps earlier. `out_sym[0]` is the parity of w AND 7'b1111001 (171 octal). `out_sym[1]` is the parity of w AND 7'b1011011 (133 octal).
- R3: Mode 0 (truncation) starts from the all-zero state, encodes d0..dN-1 and emits exactly N symbols.
- R4: Mode 1 (zero-tail) starts from the all-zero state, encodes d0..dN-1 and then six zero inputs, and emits N+6 symbols. The last symbol is formed with the sixth zero at the input, and no symbol is emitted for the shift that follows.
- R5: Mode 2 (tail biting, closing bits) first shifts dN-6..dN-1 into the delay line, oldest first, with no symbol emitted. It then encodes d0..dN-1 and emits N symbols.
- R6: Mode 3 (tail biting, opening bits) first shifts d0..d5 in with no symbol emitted. It then encodes d6..dN-1 followed by d0..d5 and emits N symbols.
- R7: `out_last` is 1 on the final symbol of each packet and 0 on every other symbol.
- R8: In modes 2 and 3, a packet of fewer than 6 bits raises `err_short` for one cycle and emits no symbols. Modes 0 and 1 encode such packets normally.
- R9: After a packet's final symbol, `state_match` shows whether the delay-line state after the last shift equals the state when encoding began (zero in modes 0 and 1, the preloaded value in modes 2 and 3). It holds that value until the next packet ends.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_sym` and `out_last` hold steady, and no symbol is lost or repeated.
- R11: `in_ready` is 1 only while a packet is being collected. A packet ends on a bit accepted with `in_last`, or on its MAX_BITS-th bit. `cfg_mode` is sampled together with the ending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 2 | Termination scheme: 0 truncation, 1 zero-tail, 2 tail biting from closing bits, 3 tail biting from opening bits |
| in_valid | input | 1 | Data bit offered |
| in_ready | output | 1 | Block is collecting a packet |
| in_bit | input | 1 | Data bit |
| in_last | input | 1 | Marks the packet's final bit |
| out_valid | output | 1 | Coded pair available |
| out_ready | input | 1 | Consumer takes the pair |
| out_sym | output | 2 | Coded pair, bit 0 from 171 octal, bit 1 from 133 octal |
| out_last | output | 1 | Final pair of the packet |
| err_short | output | 1 | One-cycle pulse: tail-biting packet shorter than 6 bits rejected |
| state_match | output | 1 | End state equals start state for the last packet |

## Verification
The bench targets the edges of the index arithmetic. These are tail-biting packets of exactly six bits, where the preload window wraps onto the whole packet and the re-encode point falls back to bit 0, and a packet that ends by filling the buffer rather than by `in_last`. A design with an off-by-one in the wrap would emit pairs built from the wrong bits. A wrong preload order would give a wrong opening pair in every tail-biting packet.

Short packets are sent in every mode. They check that tail-biting rejects them with no stray symbols, while truncation still encodes them. Zero-tail packets check that no seventh tail pair appears. Throughout, the consumer applies an irregular ready pattern, so a design that dropped or repeated a stalled pair would fall out of step with the scoreboard. Truncated packets ending in nonzero data check that the debug flag can read 0.

// File: rtl/conv_enc_pkg.sv
// Shared definitions for the packet convolutional encoder.
// Assumes a constraint length of 7 (six delay stages).
package conv_enc_pkg;

    localparam int ZLEN = 6;

    // Termination schemes, numbered as seen on cfg_mode
    typedef enum logic [1:0] {
        TERM_TRUNC   = 2'd0,
        TERM_ZTAIL   = 2'd1,
        TERM_TB_LAST = 2'd2,
        TERM_TB_FRST = 2'd3
    } term_mode_e;

    typedef enum logic [1:0] {
        SQ_FILL = 2'd0,
        SQ_PRE  = 2'd1,
        SQ_ENC  = 2'd2,
        SQ_TAIL = 2'd3
    } seq_state_e;

    function automatic logic is_tail_biting(input term_mode_e m);
        return (m == TERM_TB_LAST) || (m == TERM_TB_FRST);
    endfunction

endpackage

// File: rtl/pkt_bit_buffer.sv
// Single-bit-wide packet store: one write port, one asynchronous read port.
// Assumes the writer never addresses beyond DEPTH-1. Contents are not reset.
module pkt_bit_buffer #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_bit,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_bit
);
    logic [DEPTH-1:0] mem_q;

    // Store one packet bit per accepted write
    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= wr_bit;
    end

    // Read the bit addressed by the sequencer
    always_comb rd_bit = mem_q[rd_addr];

    // R11
    wr_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_addr) < DEPTH));
endmodule

// File: rtl/conv_shift_unit.sv
// Six-stage delay line plus the two generator parity trees.
// state_o[5] holds the most recent input. The window is {bit_in, state_o}.
// Assumes clr and shift_en are never high together.
module conv_shift_unit #(
    parameter logic [6:0] GEN_A = 7'o171,
    parameter logic [6:0] GEN_B = 7'o133,
    localparam int SW = conv_enc_pkg::ZLEN
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          shift_en,
    input  logic          bit_in,
    output logic [SW-1:0] state_o,
    output logic [SW-1:0] next_o,
    output logic [1:0]    sym_o
);
    logic [SW-1:0] sr_q;
    logic [SW:0]   window;

    // Window, parities and the state after one shift
    always_comb begin
        window  = {bit_in, sr_q};
        sym_o   = {^(window & GEN_B), ^(window & GEN_A)};
        next_o  = {bit_in, sr_q[SW-1:1]};
        state_o = sr_q;
    end

    // Delay-line update: clear at packet start, shift on request
    always_ff @(posedge clk) begin
        if (!rst_n || clr) sr_q <= '0;
        else if (shift_en) sr_q <= {bit_in, sr_q[SW-1:1]};
    end

    // R3
    clr_shift_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({clr, shift_en}));
endmodule

// File: rtl/enc_sequencer.sv
// Packet sequencer. Collects bits into the buffer, then walks the buffer
// in the order the latched termination scheme needs. Each preload step
// takes one cycle. Each encode or tail step waits for a free output slot.
// Assumes out_free reports whether the output register can take a symbol.
module enc_sequencer
    import conv_enc_pkg::*;
#(
    parameter int MAX_BITS = 64,
    localparam int AW = $clog2(MAX_BITS),
    localparam int LW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cfg_mode,
    input  logic          in_valid,
    input  logic          in_last,
    output logic          in_ready,
    input  logic          out_free,
    input  logic          rd_bit,
    output logic          buf_we,
    output logic [AW-1:0] buf_waddr,
    output logic [AW-1:0] buf_raddr,
    output logic          clr,
    output logic          shift_en,
    output logic          shift_bit,
    output logic          emit,
    output logic          emit_last,
    output logic          first_step,
    output term_mode_e    mode_o,
    output logic          err_o
);
    seq_state_e    st_q;
    term_mode_e    mode_q;
    term_mode_e    mode_in;
    logic [LW-1:0] len_q;
    logic [LW-1:0] cnt_q;
    logic [AW-1:0] idx_q;
    logic [AW-1:0] wr_q;
    logic          err_q;
    logic          accept;
    logic          pkt_end;
    logic [LW-1:0] n_new;
    logic          step;
    logic [AW-1:0] idx_nx;

    // Handshake, packet-end detection and step decode
    always_comb begin
        mode_in   = term_mode_e'(cfg_mode);
        in_ready  = (st_q == SQ_FILL);
        accept    = in_ready && in_valid;
        pkt_end   = accept && (in_last || (wr_q == AW'(MAX_BITS - 1)));
        n_new     = {1'b0, wr_q} + LW'(1);
        buf_we    = accept;
        buf_waddr = wr_q;
        buf_raddr = idx_q;
        clr       = pkt_end;
        step      = ((st_q == SQ_ENC) || (st_q == SQ_TAIL)) && out_free;
        shift_en  = (st_q == SQ_PRE) || step;
        shift_bit = (st_q == SQ_TAIL) ? 1'b0 : rd_bit;
        emit      = step;
        emit_last = step && (((st_q == SQ_ENC) && (cnt_q == len_q - LW'(1))
                               && (mode_q != TERM_ZTAIL))
                          || ((st_q == SQ_TAIL) && (cnt_q == LW'(ZLEN - 1))));
        first_step = step && (st_q == SQ_ENC) && (cnt_q == '0);
        idx_nx    = ({1'b0, idx_q} == len_q - LW'(1)) ? '0 : idx_q + AW'(1);
        mode_o    = mode_q;
        err_o     = err_q;
    end

    // Phase control, read-index walk and short-packet rejection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SQ_FILL;
            mode_q <= TERM_TRUNC;
            len_q  <= '0;
            cnt_q  <= '0;
            idx_q  <= '0;
            wr_q   <= '0;
            err_q  <= 1'b0;
        end else begin
            err_q <= 1'b0;
            unique case (st_q)
                SQ_FILL: begin
                    if (accept) wr_q <= wr_q + AW'(1);
                    if (pkt_end) begin
                        wr_q   <= '0;
                        mode_q <= mode_in;
                        len_q  <= n_new;
                        cnt_q  <= '0;
                        if (is_tail_biting(mode_in) && (n_new < LW'(ZLEN))) begin
                            err_q <= 1'b1;
                        end else if (is_tail_biting(mode_in)) begin
                            st_q  <= SQ_PRE;
                            idx_q <= (mode_in == TERM_TB_LAST) ? AW'(n_new - LW'(ZLEN)) : '0;
                        end else begin
                            st_q  <= SQ_ENC;
                            idx_q <= '0;
                        end
                    end
                end
                SQ_PRE: begin
                    idx_q <= idx_nx;
                    if (cnt_q == LW'(ZLEN - 1)) begin
                        cnt_q <= '0;
                        st_q  <= SQ_ENC;
                    end else begin
                        cnt_q <= cnt_q + LW'(1);
                    end
                end
                SQ_ENC: begin
                    if (step) begin
                        idx_q <= idx_nx;
                        if (cnt_q == len_q - LW'(1)) begin
                            cnt_q <= '0;
                            st_q  <= (mode_q == TERM_ZTAIL) ? SQ_TAIL : SQ_FILL;
                        end else begin
                            cnt_q <= cnt_q + LW'(1);
                        end
                    end
                end
                SQ_TAIL: begin
                    if (step) begin
                        if (cnt_q == LW'(ZLEN - 1)) begin
                            cnt_q <= '0;
                            st_q  <= SQ_FILL;
                        end else begin
                            cnt_q <= cnt_q + LW'(1);
                        end
                    end
                end
                default: st_q <= SQ_FILL;
            endcase
        end
    end

    // R5
    preload_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SQ_PRE) |-> (cnt_q < LW'(ZLEN)) && !emit);

    // R8
    err_no_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> (st_q == SQ_FILL) && !emit);

    // R4
    tail_only_zero_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SQ_TAIL) |-> (mode_q == TERM_ZTAIL));
endmodule

// File: rtl/conv_pkt_encoder.sv
// Top: rate-1/2, constraint-length-7 packet encoder with four termination
// schemes. Owns the output register and the end-state debug flag.
// Assumes cfg_mode is valid when the packet's ending bit is offered.
module conv_pkt_encoder
    import conv_enc_pkg::*;
#(
    parameter int MAX_BITS = 64,
    parameter logic [6:0] GEN_A = 7'o171,
    parameter logic [6:0] GEN_B = 7'o133
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cfg_mode,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic       in_bit,
    input  logic       in_last,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [1:0] out_sym,
    output logic       out_last,
    output logic       err_short,
    output logic       state_match
);
    localparam int AW = $clog2(MAX_BITS);

    logic          buf_we;
    logic [AW-1:0] buf_waddr;
    logic [AW-1:0] buf_raddr;
    logic          rd_bit;
    logic          clr;
    logic          shift_en;
    logic          shift_bit;
    logic          emit;
    logic          emit_last;
    logic          first_step;
    term_mode_e    mode;
    logic          out_free;
    logic [ZLEN-1:0] cur_state;
    logic [ZLEN-1:0] next_state;
    logic [ZLEN-1:0] seed_q;
    logic [ZLEN-1:0] seed_ref;
    logic [1:0]      sym;
    logic            ov_q;
    logic [1:0]      sym_q;
    logic            last_q;
    logic            match_q;

    pkt_bit_buffer #(.DEPTH(MAX_BITS)) buf_i (
        .clk(clk), .rst_n(rst_n), .wr_en(buf_we), .wr_addr(buf_waddr),
        .wr_bit(in_bit), .rd_addr(buf_raddr), .rd_bit(rd_bit)
    );

    enc_sequencer #(.MAX_BITS(MAX_BITS)) seq_i (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .in_valid(in_valid),
        .in_last(in_last), .in_ready(in_ready), .out_free(out_free),
        .rd_bit(rd_bit), .buf_we(buf_we), .buf_waddr(buf_waddr),
        .buf_raddr(buf_raddr), .clr(clr), .shift_en(shift_en),
        .shift_bit(shift_bit), .emit(emit), .emit_last(emit_last),
        .first_step(first_step), .mode_o(mode), .err_o(err_short)
    );

    conv_shift_unit #(.GEN_A(GEN_A), .GEN_B(GEN_B)) sh_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .shift_en(shift_en),
        .bit_in(shift_bit), .state_o(cur_state), .next_o(next_state),
        .sym_o(sym)
    );

    // Output slot is free when empty or being drained this cycle
    always_comb begin
        out_free    = !ov_q || out_ready;
        seed_ref    = first_step ? cur_state : seed_q;
        out_valid   = ov_q;
        out_sym     = sym_q;
        out_last    = last_q;
        state_match = match_q;
    end

    // Output register: load on emit, clear once consumed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ov_q   <= 1'b0;
            sym_q  <= '0;
            last_q <= 1'b0;
        end else if (emit) begin
            ov_q   <= 1'b1;
            sym_q  <= sym;
            last_q <= emit_last;
        end else if (out_ready) begin
            ov_q   <= 1'b0;
        end
    end

    // Capture the start state and judge the end state of each packet
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seed_q  <= '0;
            match_q <= 1'b0;
        end else begin
            if (first_step) seed_q <= cur_state;
            if (emit && emit_last) match_q <= (next_state == seed_ref);
        end
    end

    // R10
    hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable(out_sym) && $stable(out_last));

    // R4
    ztail_ends_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (emit && emit_last && (mode == TERM_ZTAIL)) |-> (next_state == '0));

    // R9
    tb_state_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (emit && emit_last && is_tail_biting(mode)) |=> state_match);

    // R11
    no_input_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        emit |-> !in_ready);
endmodule

// File: tb/conv_pkt_encoder_tb_top.sv
`timescale 1ns/1ps
module conv_pkt_encoder_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_mode = 2'd0;
    logic       in_valid = 1'b0;
    logic       in_bit = 1'b0;
    logic       in_last = 1'b0;
    logic       out_ready = 1'b1;
    logic       in_ready;
    logic       out_valid;
    logic [1:0] out_sym;
    logic       out_last;
    logic       err_short;
    logic       state_match;

    int total = 0;
    int bad = 0;
    int err_cnt = 0;
    int got_cnt = 0;
    bit ready_rand = 1'b0;
    bit done = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    bit   pkt [0:63];
    logic [2:0] exp_q [$];
    bit   exp_match;
    bit   stalled = 1'b0;
    logic [2:0] stall_val;

    always #2 clk = ~clk;

    conv_pkt_encoder dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .in_valid(in_valid),
        .in_ready(in_ready), .in_bit(in_bit), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_sym(out_sym),
        .out_last(out_last), .err_short(err_short), .state_match(state_match)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Consumer ready pattern, changed just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = ready_rand ? (lfsr[0] | lfsr[3]) : 1'b1;
        end
    end

    // Monitor: scoreboard pops, stall stability, error pulse count
    always @(negedge clk) begin
        if (rst_n) begin
            if (err_short) err_cnt++;
            if (stalled && out_valid) begin
                // R10
                check({out_last, out_sym} == stall_val, "R10 stall", {out_last, out_sym}, stall_val);
            end
            stalled = out_valid && !out_ready;
            stall_val = {out_last, out_sym};
            if (out_valid && out_ready) begin
                got_cnt++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8/R4 unexpected symbol", {out_last, out_sym}, -1);
                end else begin
                    logic [2:0] e;
                    e = exp_q.pop_front();
                    // R2 R7 symbol and last flag
                    check({out_last, out_sym} == e, "R2/R7 symbol", {out_last, out_sym}, e);
                end
            end
        end
    end

    // Reference model from R2..R6: fills the expected queue
    task automatic build_expect(input int mode, input int n);
        bit seq [0:69];
        int sl = 0;
        logic [5:0] st = '0;
        logic [5:0] seed;
        if (mode == 2) for (int k = 0; k < 6; k++) st = {pkt[n-6+k], st[5:1]};
        if (mode == 3) for (int k = 0; k < 6; k++) st = {pkt[k], st[5:1]};
        seed = st;
        if (mode == 3) begin
            for (int k = 6; k < n; k++) begin seq[sl] = pkt[k]; sl++; end
            for (int k = 0; k < 6; k++) begin seq[sl] = pkt[k]; sl++; end
        end else begin
            for (int k = 0; k < n; k++) begin seq[sl] = pkt[k]; sl++; end
            if (mode == 1) for (int k = 0; k < 6; k++) begin seq[sl] = 1'b0; sl++; end
        end
        for (int k = 0; k < sl; k++) begin
            logic [6:0] w;
            logic a, b;
            w = {seq[k], st};
            a = ^(w & 7'b1111001);
            b = ^(w & 7'b1011011);
            exp_q.push_back({(k == sl - 1), b, a});
            st = {seq[k], st[5:1]};
        end
        exp_match = (st == seed);
    endtask

    // Driver: predicts, sends a packet, waits for drain and checks flags
    task automatic run_pkt(input int mode, input int n, input bit use_last, input string req);
        bit short_tb;
        int e0;
        int exp_syms;
        short_tb = (mode >= 2) && (n < 6);
        e0 = err_cnt;
        got_cnt = 0;
        exp_syms = short_tb ? 0 : ((mode == 1) ? n + 6 : n);
        if (!short_tb) build_expect(mode, n);
        @(posedge clk);
        #1;
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1;
            in_bit = pkt[i];
            in_last = use_last && (i == n - 1);
            cfg_mode = (i == n - 1) ? mode[1:0] : ~mode[1:0];
            forever begin
                @(negedge clk);
                if (in_ready) break;
                @(posedge clk);
                #1;
            end
            @(posedge clk);
            #1;
        end
        in_valid = 1'b0;
        in_last = 1'b0;
        @(negedge clk);
        if (!short_tb) begin
            // R11 input closed while the packet is encoded
            check(in_ready == 1'b0, {req, " R11 busy"}, in_ready, 0);
        end
        for (int t = 0; t < 400; t++) begin
            if (exp_q.size() == 0 && !out_valid) break;
            @(negedge clk);
        end
        repeat (4) @(negedge clk);
        check(got_cnt == exp_syms, {req, " symbol count"}, got_cnt, exp_syms);
        if (short_tb) begin
            // R8 one error pulse
            check(err_cnt - e0 == 1, {req, " R8 err pulse"}, err_cnt - e0, 1);
        end else begin
            // R9 end-state flag
            check(state_match == exp_match, {req, " R9 match"}, state_match, exp_match);
            check(err_cnt == e0, {req, " R8 no err"}, err_cnt - e0, 0);
        end
    endtask

    task automatic fill_pattern(input int seed, input int n);
        logic [31:0] x = 32'h1234_5678 ^ seed;
        for (int i = 0; i < n; i++) begin
            x = x * 32'd1103515245 + 32'd12345;
            pkt[i] = x[16];
        end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1 during reset
        check(!out_valid && !err_short && !state_match && in_ready, "R1 in reset",
              {out_valid, err_short, state_match, in_ready}, 1);
        @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 after release
        check(!out_valid && !err_short && !state_match && in_ready, "R1 after reset",
              {out_valid, err_short, state_match, in_ready}, 1);

        fill_pattern(1, 10); pkt[9] = 1'b1;
        run_pkt(0, 10, 1'b1, "R3 trunc");
        fill_pattern(2, 8);
        run_pkt(1, 8, 1'b1, "R4 ztail");
        ready_rand = 1'b1;
        fill_pattern(3, 20);
        run_pkt(2, 20, 1'b1, "R5 tb-last");
        fill_pattern(4, 20);
        run_pkt(3, 20, 1'b1, "R6 tb-first");
        fill_pattern(5, 6);
        run_pkt(2, 6, 1'b1, "R5 tb-last N6");
        fill_pattern(6, 6);
        run_pkt(3, 6, 1'b1, "R6 tb-first N6");
        fill_pattern(7, 5);
        run_pkt(3, 5, 1'b1, "R8 short tb-first");
        fill_pattern(8, 3);
        run_pkt(2, 3, 1'b1, "R8 short tb-last");
        pkt[0] = 1'b1; pkt[1] = 1'b0; pkt[2] = 1'b1;
        run_pkt(0, 3, 1'b1, "R8 short trunc");
        fill_pattern(9, 64);
        run_pkt(1, 64, 1'b0, "R11 full ztail");
        fill_pattern(10, 64);
        run_pkt(3, 64, 1'b0, "R11 full tb-first");
        fill_pattern(11, 12);
        for (int i = 6; i < 12; i++) pkt[i] = 1'b0;
        run_pkt(0, 12, 1'b1, "R9 trunc zero end");
        fill_pattern(12, 33);
        run_pkt(2, 33, 1'b1, "R5 tb-last odd");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule